// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This controller sits beside the stage registers of a five-stage in-order pipeline. It reads the source register numbers and their use flags from the instruction being decoded, and the memory-read flag and destination register of the instruction in execute. It also reads the branch decision made in decode and the overflow flag and PC of the instruction in execute. From these inputs it drives the write enables of the program counter and the fetch/decode register, a select that zeroes the control word entering execute, and three flush lines. It also drives a next-PC select, a constant trap vector and a captured faulting-instruction address.

Three hazards are resolved, and their priority is fixed. An arithmetic overflow in execute wins: all three younger stages are flushed and fetch is redirected to the trap vector. A taken branch resolved in decode comes next: the wrong-path fetch is squashed to a nop and the branch target is selected. A load whose result feeds the next instruction comes last: the front end is frozen for one cycle while a bubble is injected into execute. The outputs are combinational in the stage fields, so the surrounding pipeline sees each action in the same cycle as its cause. The only state is the captured fault address.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_dst` is non-zero and equals a decode source whose use flag is 1, and neither overflow nor a taken branch is present, the block drives `pc_we`=0, `ifid_we`=0 and `id_ctrl_zero`=1 in that same cycle. The flush outputs are 0 and `pc_sel`=2'b00.
- R2: A decode source whose use flag is 0 never causes a stall, even if its register number equals `ex_dst`. Source k occupies bits [5k+4:5k] of `id_src`, and its use flag is bit k of `id_src_used`.
- R3: A load whose destination is register 0 never causes a stall.
- R4: With `ex_mem_rd`=0, or with no matching source, and no branch or overflow, the block is idle: `pc_we`=1, `ifid_we`=1, `id_ctrl_zero`=0, all flushes are 0 and `pc_sel`=2'b00.
- R5: A taken branch (`id_br_taken`=1) without overflow drives `if_flush`=1 and `pc_sel`=2'b01. `pc_we` and `ifid_we` stay 1, and `id_flush`, `ex_flush` and `id_ctrl_zero` stay 0.
- R6: Overflow (`ex_ovf`=1) drives `if_flush`, `id_flush` and `ex_flush` to 1 and `pc_sel`=2'b10, with `pc_we`=1 and `ifid_we`=1.
- R7: `exc_vector` always equals 32'h4000_0040.
- R8: Overflow takes priority over a taken branch and over a load-use stall. A taken branch takes priority over a load-use stall, so no stall is signalled in that cycle.
- R9: `epc` resets to 0. At each clock edge where `ex_ovf`=1 it loads `ex_pc`, and otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_src | input | 10 | Source register numbers of the decode instruction, 5 bits each |
| id_src_used | input | 2 | Per-source flag: the source is really read |
| ex_mem_rd | input | 1 | Memory-read control bit of the instruction in execute |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| ex_ovf | input | 1 | Arithmetic overflow detected in execute |
| ex_pc | input | 32 | Address of the instruction in execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| id_ctrl_zero | output | 1 | Zero the control word entering execute (bubble) |
| if_flush | output | 1 | Replace the fetched instruction with a nop |
| id_flush | output | 1 | Zero the decode-stage control lines |
| ex_flush | output | 1 | Zero the execute-stage control lines |
| pc_sel | output | 2 | Next PC: 00 sequential, 01 branch target, 10 trap vector |
| exc_vector | output | 32 | Trap vector address |
| epc | output | 32 | Captured address of the faulting instruction |

## Verification
The hardest situation to reach is all three causes in one cycle: an overflow, a taken branch and a load whose destination matches a used source. This is where R8 decides every output. Random stimulus alone reaches it rarely, so directed cycles build this triple and the branch-plus-load pair explicitly. The random phase then draws register numbers from a small pool and raises each flag with high probability, so that coincident causes recur often. The cases where a match is gated off by a clear use flag or by a zero destination are also placed deliberately.

// File: rtl/phc_pkg.sv
package phc_pkg;

   typedef enum logic [1:0] {
      PCSEL_SEQ    = 2'b00,
      PCSEL_BRANCH = 2'b01,
      PCSEL_VECTOR = 2'b10
   } pc_sel_e;

   typedef struct packed {
      logic fault;
      logic squash;
      logic stall;
   } hazard_t;

endpackage

// File: rtl/phc_load_use.sv
module phc_load_use #(
   parameter int REG_AW       = 5,
   parameter int NUM_SRC      = 2,
   parameter bit R0_HARDWIRED = 1'b1
) (
   input  logic                      ex_mem_rd,
   input  logic [REG_AW-1:0]         ex_dst,
   input  logic [NUM_SRC*REG_AW-1:0] id_src,
   input  logic [NUM_SRC-1:0]        id_src_used,
   output logic                      hit
);

   logic [NUM_SRC-1:0] src_match;
   logic               dst_live;

   generate
      if (R0_HARDWIRED) begin : g_r0_zero
         assign dst_live = |ex_dst;
      end else begin : g_r0_plain
         assign dst_live = 1'b1;
      end
   endgenerate

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         assign src_match[k] = id_src_used[k] &&
                               (id_src[k*REG_AW +: REG_AW] == ex_dst);
      end
   endgenerate

   assign hit = ex_mem_rd && dst_live && (|src_match);

endmodule

// File: rtl/phc_arbiter.sv
module phc_arbiter
   import phc_pkg::*;
(
   input  logic    fault_req,
   input  logic    squash_req,
   input  logic    stall_req,
   output hazard_t grant
);

   always_comb begin
      grant = '0;
      if (fault_req)       grant.fault  = 1'b1;
      else if (squash_req) grant.squash = 1'b1;
      else if (stall_req)  grant.stall  = 1'b1;
   end

endmodule

// File: rtl/phc_exc_unit.sv
module phc_exc_unit #(
   parameter int               XLEN    = 32,
   parameter logic [XLEN-1:0]  EXC_VEC = 32'h4000_0040
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [XLEN-1:0] fault_pc,
   output logic [XLEN-1:0] epc,
   output logic [XLEN-1:0] vector
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    epc <= '0;
      else if (take) epc <= fault_pc;
   end

   assign vector = EXC_VEC;

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import phc_pkg::*;
#(
   parameter int               REG_AW       = 5,
   parameter int               NUM_SRC      = 2,
   parameter int               XLEN         = 32,
   parameter logic [XLEN-1:0]  EXC_VEC      = 32'h4000_0040,
   parameter bit               R0_HARDWIRED = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*REG_AW-1:0] id_src,
   input  logic [NUM_SRC-1:0]        id_src_used,
   input  logic                      ex_mem_rd,
   input  logic [REG_AW-1:0]         ex_dst,
   input  logic                      id_br_taken,
   input  logic                      ex_ovf,
   input  logic [XLEN-1:0]           ex_pc,
   output logic                      pc_we,
   output logic                      ifid_we,
   output logic                      id_ctrl_zero,
   output logic                      if_flush,
   output logic                      id_flush,
   output logic                      ex_flush,
   output logic [1:0]                pc_sel,
   output logic [XLEN-1:0]           exc_vector,
   output logic [XLEN-1:0]           epc
);

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("pipe_hazard_ctl: REG_AW out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("pipe_hazard_ctl: NUM_SRC out of range");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("pipe_hazard_ctl: XLEN too small");
      end
   endgenerate

   logic    lu_hit;
   hazard_t grant;
   pc_sel_e sel;

   phc_load_use #(
      .REG_AW      (REG_AW),
      .NUM_SRC     (NUM_SRC),
      .R0_HARDWIRED(R0_HARDWIRED)
   ) u_load_use (
      .ex_mem_rd  (ex_mem_rd),
      .ex_dst     (ex_dst),
      .id_src     (id_src),
      .id_src_used(id_src_used),
      .hit        (lu_hit)
   );

   phc_arbiter u_arb (
      .fault_req (ex_ovf),
      .squash_req(id_br_taken),
      .stall_req (lu_hit),
      .grant     (grant)
   );

   phc_exc_unit #(
      .XLEN   (XLEN),
      .EXC_VEC(EXC_VEC)
   ) u_exc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (grant.fault),
      .fault_pc(ex_pc),
      .epc     (epc),
      .vector  (exc_vector)
   );

   always_comb begin
      sel = PCSEL_SEQ;
      if (grant.fault)       sel = PCSEL_VECTOR;
      else if (grant.squash) sel = PCSEL_BRANCH;
   end

   assign pc_we        = ~grant.stall;
   assign ifid_we      = ~grant.stall;
   assign id_ctrl_zero =  grant.stall;
   assign if_flush     =  grant.fault | grant.squash;
   assign id_flush     =  grant.fault;
   assign ex_flush     =  grant.fault;
   assign pc_sel       =  sel;

endmodule

// File: rtl/phc_chk.sv
module phc_chk #(
   parameter int               REG_AW       = 5,
   parameter int               NUM_SRC      = 2,
   parameter int               XLEN         = 32,
   parameter logic [XLEN-1:0]  EXC_VEC      = 32'h4000_0040,
   parameter bit               R0_HARDWIRED = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_SRC*REG_AW-1:0] id_src,
   input logic [NUM_SRC-1:0]        id_src_used,
   input logic                      ex_mem_rd,
   input logic [REG_AW-1:0]         ex_dst,
   input logic                      id_br_taken,
   input logic                      ex_ovf,
   input logic [XLEN-1:0]           ex_pc,
   input logic                      pc_we,
   input logic                      ifid_we,
   input logic                      id_ctrl_zero,
   input logic                      if_flush,
   input logic                      id_flush,
   input logic                      ex_flush,
   input logic [1:0]                pc_sel,
   input logic [XLEN-1:0]           exc_vector,
   input logic [XLEN-1:0]           epc
);

   logic any_match;
   always_comb begin
      any_match = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
         if (id_src_used[k] && id_src[k*REG_AW +: REG_AW] == ex_dst)
            any_match = 1'b1;
   end

   // R1
   a_r1_load_use_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_mem_rd && ex_dst != '0 && any_match && !ex_ovf && !id_br_taken)
      |-> (!pc_we && !ifid_we && id_ctrl_zero && !if_flush && pc_sel == 2'b00));

   // R3
   a_r3_reg0_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_dst == '0 || !ex_mem_rd) |-> (pc_we && ifid_we && !id_ctrl_zero));

   // R5
   a_r5_branch_squash: assert property (@(posedge clk) disable iff (!rst_n)
      (id_br_taken && !ex_ovf) |-> (if_flush && !id_flush && !ex_flush &&
                                    pc_we && pc_sel == 2'b01));

   // R6
   a_r6_overflow_flush: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf |-> (if_flush && id_flush && ex_flush && pc_we && ifid_we &&
                  !id_ctrl_zero && pc_sel == 2'b10));

   // R7
   a_r7_vector_value: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vector == EXC_VEC);

   // R8
   a_r8_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({id_ctrl_zero, id_flush, (if_flush && !id_flush)}) <= 1);

   // R9
   a_r9_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf |=> (epc == $past(ex_pc)));

   a_r9_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_ovf |=> $stable(epc));

endmodule

bind pipe_hazard_ctl phc_chk #(
   .REG_AW      (REG_AW),
   .NUM_SRC     (NUM_SRC),
   .XLEN        (XLEN),
   .EXC_VEC     (EXC_VEC),
   .R0_HARDWIRED(R0_HARDWIRED)
) u_chk (.*);

// File: tb/pipe_hazard_ctl_tb.sv
`timescale 1ns/100ps
module pipe_hazard_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  id_src = '0;
   logic [1:0]  id_src_used = '0;
   logic        ex_mem_rd = 1'b0;
   logic [4:0]  ex_dst = '0;
   logic        id_br_taken = 1'b0;
   logic        ex_ovf = 1'b0;
   logic [31:0] ex_pc = '0;
   logic        pc_we, ifid_we, id_ctrl_zero, if_flush, id_flush, ex_flush;
   logic [1:0]  pc_sel;
   logic [31:0] exc_vector, epc;

   int checks = 0;
   int errors = 0;
   logic [31:0] epc_m = '0;

   always #2 clk = ~clk;

   pipe_hazard_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_src_used(id_src_used),
      .ex_mem_rd(ex_mem_rd), .ex_dst(ex_dst), .id_br_taken(id_br_taken),
      .ex_ovf(ex_ovf), .ex_pc(ex_pc), .pc_we(pc_we), .ifid_we(ifid_we),
      .id_ctrl_zero(id_ctrl_zero), .if_flush(if_flush), .id_flush(id_flush),
      .ex_flush(ex_flush), .pc_sel(pc_sel), .exc_vector(exc_vector), .epc(epc)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic mr, input logic [4:0] dst,
                      input logic [4:0] rs, input logic [4:0] rt,
                      input logic urs, input logic urt,
                      input logic br, input logic ovf,
                      input logic [31:0] pc, input string tag_in);
      logic hit, stall, squash;
      logic [1:0] sel;
      string tag;
      @(negedge clk);
      ex_mem_rd = mr; ex_dst = dst; id_src = {rt, rs};
      id_src_used = {urt, urs}; id_br_taken = br; ex_ovf = ovf; ex_pc = pc;
      #1;
      hit = 1'b0;
      if (mr && dst != 5'd0) begin
         if (urs && rs == dst) hit = 1'b1;
         if (urt && rt == dst) hit = 1'b1;
      end
      squash = br && !ovf;
      stall  = hit && !ovf && !br;
      sel    = ovf ? 2'b10 : (squash ? 2'b01 : 2'b00);
      if (tag_in != "") tag = tag_in;
      else if (ovf)     tag = "R6";
      else if (squash)  tag = "R5";
      else if (stall)   tag = "R1";
      else              tag = "R4";
      chk(tag, "pc_we",        {31'd0, pc_we},        {31'd0, !stall});
      chk(tag, "ifid_we",      {31'd0, ifid_we},      {31'd0, !stall});
      chk(tag, "id_ctrl_zero", {31'd0, id_ctrl_zero}, {31'd0, stall});
      chk(tag, "if_flush",     {31'd0, if_flush},     {31'd0, ovf | squash});
      chk(tag, "id_flush",     {31'd0, id_flush},     {31'd0, ovf});
      chk(tag, "ex_flush",     {31'd0, ex_flush},     {31'd0, ovf});
      chk(tag, "pc_sel",       {30'd0, pc_sel},       {30'd0, sel});
      chk("R7", "exc_vector",  exc_vector,            32'h4000_0040);
      chk("R9", "epc",         epc,                   epc_m);
      @(posedge clk);
      if (rst_n && ovf) epc_m = pc;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // reset state (R9 reset value, R4 idle outputs)
      cyc(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R9");
      cyc(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R4");
      @(negedge clk); rst_n = 1'b1;
      // R1 load-use on first and second source
      cyc(1'b1, 5'd7, 5'd7, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h100, "R1");
      cyc(1'b1, 5'd9, 5'd2, 5'd9, 1'b1, 1'b1, 1'b0, 1'b0, 32'h104, "R1");
      // R2 matching but unused source
      cyc(1'b1, 5'd7, 5'd7, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h108, "R2");
      cyc(1'b1, 5'd9, 5'd2, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 32'h10c, "R2");
      // R3 load to register 0
      cyc(1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h110, "R3");
      // R4 non-load producer with match
      cyc(1'b0, 5'd5, 5'd5, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 32'h114, "R4");
      // R5 taken branch
      cyc(1'b0, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b1, 1'b0, 32'h118, "R5");
      // R6 overflow, then R9 capture and hold
      cyc(1'b0, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_1234, "R6");
      cyc(1'b0, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_5678, "R9");
      cyc(1'b0, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_9abc, "R9");
      // R8 priorities
      cyc(1'b1, 5'd4, 5'd4, 5'd4, 1'b1, 1'b1, 1'b1, 1'b1, 32'hdead_0000, "R8");
      cyc(1'b1, 5'd4, 5'd4, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0, 32'hdead_0004, "R8");
      cyc(1'b1, 5'd4, 5'd4, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 32'hdead_0008, "R8");
      // random phase
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 2) == 0, 5'($urandom % 4), 5'($urandom % 4),
             5'($urandom % 4), ($urandom % 4) != 0, ($urandom % 4) != 0,
             ($urandom % 4) == 0, ($urandom % 6) == 0, $urandom, "");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule